// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block keeps an asynchronous DRAM's contents alive and brings it up after power-on. Once reset is released it waits a fixed power-up interval and then runs a burst of warm-up refresh cycles. Only after that does it report the memory as usable. From then on a free-running interval counter adds one refresh credit per refresh slot. Credits that cannot be served at once are banked up to a small limit. The block asks the access arbiter for the memory with `req_o`, and each refresh cycle starts only while `gnt_i` is high. Under one grant it drains all banked credits, one cycle after another.

Every refresh it performs is a CAS-before-RAS cycle. Both byte CAS strobes drop first and RAS follows a set number of clocks later. Both CAS strobes stay low for the whole RAS-low time, and then all strobes return high for a precharge gap. WE never leaves its high level, and no address is needed because the device supplies the row itself. An idle watchdog is cleared by any strobe activity, whether reported by the access path on `act_i` or made by the block's own cycles. If the watchdog runs out, `ready_o` drops, the credit bank is cleared and the warm-up burst runs again.

The controller states are ST_PAUSE (power-up wait), ST_WAIT (idle or asking for the bus), ST_CAS (CAS low, RAS high), ST_RAS (RAS and CAS low) and ST_PRE (all strobes high). The transitions are: PAUSE to WAIT when the wait count expires; WAIT to CAS when work is pending and the grant is high; CAS to RAS after the CAS lead time; RAS to PRE after the RAS-low time; PRE to WAIT after the precharge time. Work means a warm-up cycle is still owed, or, once ready, at least one credit is banked. Timing at the default 4 ns clock is 3 cycles of CAS lead, 13 cycles of RAS low and 7 cycles of precharge. The one WAIT cycle between cycles is added to the precharge gap.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset release, `req_o` and `ready_o` stay low for PAUSE_CYC cycles. During reset, all strobe outputs are high.
- R2: After the pause, exactly WARMUP_CNT refresh cycles are performed. `ready_o` rises at the end of the last one.
- R3: While ready, one credit is added every REF_TICK cycles. At most MAX_PEND credits are banked, and further credits are dropped.
- R4: `req_o` is high while work is pending or a cycle is in progress. A cycle starts only when `gnt_i` is high. Under a held grant, all banked credits are served before `req_o` falls.
- R5: Both CAS strobes fall together exactly CSR_CYC cycles before RAS falls. Both stay low for as long as RAS is low.
- R6: RAS stays low exactly RAS_LOW_CYC cycles. Inside a burst, the next CAS fall comes exactly PRE_CYC+1 cycles after RAS rises.
- R7: `we_n_o` is always high. No strobe is low unless `gnt_i` is high.
- R8: After IDLE_LIMIT cycles with no strobe activity, `ready_o` falls and a fresh burst of WARMUP_CNT cycles must complete before it rises again.
- R9: Pulses on `act_i` spaced closer than IDLE_LIMIT keep `ready_o` high even while refresh is withheld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Strobe activity by the normal access path |
| gnt_i | input | 1 | Arbiter grant of the memory strobes |
| req_o | output | 1 | Request for the memory strobes |
| ready_o | output | 1 | Memory initialized and usable |
| ras_n_o | output | 1 | Row strobe, active low |
| casu_n_o | output | 1 | Upper-byte column strobe, active low |
| casl_n_o | output | 1 | Lower-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
The checker watches the strobe waveform on every clock. It confirms that CAS leads RAS by the set count, that CAS covers the whole RAS-low time, that the RAS-low width is exact, that WE stays high and that strobes are owned only under grant. It also confirms that the credit bank never exceeds its limit, that nothing is requested during the pause, and that readiness appears only at the end of a cycle. Only the bench scenarios can show the counts that span many cycles. These are the length of the power-up wait, the number of warm-up cycles, the refresh rate over a long window, the size of the drained backlog under withheld grant, and the watchdog expiring or being held off by activity pulses.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_WAIT,
        ST_CAS,
        ST_RAS,
        ST_PRE
    } rs_state_t;
endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
    parameter int PERIOD = 3800
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = $clog2(PERIOD + 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
    parameter int MAX = 4,
    localparam int BW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [BW-1:0] level
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (level != BW'(MAX)) level <= level + 1'b1;
                2'b01:   if (level != '0)       level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/idle_watch.sv
module idle_watch #(
    parameter int LIMIT = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic act,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expire = en && !act && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en || act || expire) cnt <= '0;
        else                                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int PAUSE_CYC   = 50000,
    parameter int REF_TICK    = 3800,
    parameter int MAX_PEND    = 4,
    parameter int WARMUP_CNT  = 8,
    parameter int IDLE_LIMIT  = 2000000,
    parameter int CSR_CYC     = 3,
    parameter int RAS_LOW_CYC = 13,
    parameter int PRE_CYC     = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic gnt_i,
    output logic req_o,
    output logic ready_o,
    output logic ras_n_o,
    output logic casu_n_o,
    output logic casl_n_o,
    output logic we_n_o
);
    localparam int M1 = (CSR_CYC > RAS_LOW_CYC) ? CSR_CYC : RAS_LOW_CYC;
    localparam int M2 = (M1 > PRE_CYC) ? M1 : PRE_CYC;
    localparam int PH_MAX = (PAUSE_CYC > M2) ? PAUSE_CYC : M2;
    localparam int CW = $clog2(PH_MAX + 1);
    localparam int WW = $clog2(WARMUP_CNT + 1);
    localparam int BW = $clog2(MAX_PEND + 1);

    rs_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [WW-1:0] warm_left;
    logic [BW-1:0] pend_lvl;
    logic          ready_q;
    logic          tick, idle_exp, cyc_done, work;

    ref_tick_gen #(.PERIOD(REF_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ref_backlog #(.MAX(MAX_PEND)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_exp),
        .inc   (tick && ready_q),
        .dec   (cyc_done && ready_q),
        .level (pend_lvl)
    );

    idle_watch #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state != ST_PAUSE),
        .act    (act_i || (state == ST_RAS)),
        .expire (idle_exp)
    );

    assign cyc_done = (state == ST_PRE) && (cnt == CW'(PRE_CYC - 1));
    assign work     = ready_q ? (pend_lvl != '0) : (warm_left != '0);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PAUSE: if (cnt == CW'(PAUSE_CYC - 1))   nxt = ST_WAIT;
            ST_WAIT:  if (work && gnt_i)              nxt = ST_CAS;
            ST_CAS:   if (cnt == CW'(CSR_CYC - 1))     nxt = ST_RAS;
            ST_RAS:   if (cnt == CW'(RAS_LOW_CYC - 1)) nxt = ST_PRE;
            ST_PRE:   if (cyc_done)                   nxt = ST_WAIT;
            default:                                  nxt = ST_PAUSE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
        end
    end

    // warm-up bookkeeping and readiness
    always_ff @(posedge clk) begin
        if (!rst_n || idle_exp) begin
            ready_q   <= 1'b0;
            warm_left <= WW'(WARMUP_CNT);
        end else if (cyc_done && !ready_q) begin
            if (warm_left == WW'(1)) begin
                ready_q   <= 1'b1;
                warm_left <= '0;
            end else begin
                warm_left <= warm_left - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ready_o  = ready_q;
        we_n_o   = 1'b1;
        ras_n_o  = 1'b1;
        casu_n_o = 1'b1;
        casl_n_o = 1'b1;
        req_o    = 1'b0;
        unique case (state)
            ST_PAUSE: req_o = 1'b0;
            ST_WAIT:  req_o = work;
            ST_CAS: begin
                req_o    = 1'b1;
                casu_n_o = 1'b0;
                casl_n_o = 1'b0;
            end
            ST_RAS: begin
                req_o    = 1'b1;
                ras_n_o  = 1'b0;
                casu_n_o = 1'b0;
                casl_n_o = 1'b0;
            end
            ST_PRE:   req_o = 1'b1;
            default:  req_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk
    import dram_ref_pkg::*;
#(
    parameter int MAX_PEND    = 4,
    parameter int CSR_CYC     = 3,
    parameter int RAS_LOW_CYC = 13,
    localparam int BW = $clog2(MAX_PEND + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gnt_i,
    input logic          req_o,
    input logic          ready_o,
    input logic          ras_n_o,
    input logic          casu_n_o,
    input logic          casl_n_o,
    input logic          we_n_o,
    input logic [BW-1:0] pend_lvl,
    input rs_state_t     state
);
    logic [15:0] lead_cnt, low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_cnt <= '0;
            low_cnt  <= '0;
        end else begin
            lead_cnt <= (!casu_n_o && ras_n_o && lead_cnt != 16'hFFFF) ? lead_cnt + 1'b1 : '0;
            low_cnt  <= (!ras_n_o && low_cnt != 16'hFFFF) ? low_cnt + 1'b1 : '0;
        end
    end

    p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE) |-> (!req_o && !ready_o));

    p_ready_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(state) == ST_PRE));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_lvl <= BW'(MAX_PEND));

    p_start_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(casu_n_o) |-> $past(gnt_i));

    p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (lead_cnt == 16'(CSR_CYC)));

    p_cas_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> (!casu_n_o && !casl_n_o));

    p_ras_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (low_cnt == 16'(RAS_LOW_CYC)));

    p_we_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we_n_o);

    p_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o || !casu_n_o || !casl_n_o) |-> gnt_i);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .MAX_PEND    (MAX_PEND),
    .CSR_CYC     (CSR_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt_i    (gnt_i),
    .req_o    (req_o),
    .ready_o  (ready_o),
    .ras_n_o  (ras_n_o),
    .casu_n_o (casu_n_o),
    .casl_n_o (casl_n_o),
    .we_n_o   (we_n_o),
    .pend_lvl (pend_lvl),
    .state    (state)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
    localparam int P    = 40;
    localparam int TICK = 150;
    localparam int IDLE = 400;
    localparam int WARM = 8;
    localparam int MAXP = 4;
    localparam int CSR  = 3;
    localparam int RASL = 13;
    localparam int PRE  = 7;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, act, gnt;
    logic req, ready, ras_n, cu, cl, we;

    dram_refresh_sched #(
        .PAUSE_CYC(P), .REF_TICK(TICK), .MAX_PEND(MAXP), .WARMUP_CNT(WARM),
        .IDLE_LIMIT(IDLE), .CSR_CYC(CSR), .RAS_LOW_CYC(RASL), .PRE_CYC(PRE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .act_i(act), .gnt_i(gnt), .req_o(req),
        .ready_o(ready), .ras_n_o(ras_n), .casu_n_o(cu), .casl_n_o(cl), .we_n_o(we)
    );

    int  n_chk = 0, n_bad = 0;
    int  cyc = 0, ras_falls = 0, last_act = 0;
    bit  auto_gnt = 0, act_en = 0, done = 0;

    task automatic check(input bit ok, input string tag, input int actv, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, actv, expv, cyc);
        end
    endtask

    function automatic bit in_range(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // strobe monitor, sampled on the falling edge
    bit prev_ras = 1, prev_cu = 1, have_rise = 0, gnt_held = 0;
    int cas_pre = 0, low_len = 0, hi_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!ras_n || act) last_act = cyc;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                check(cas_pre == CSR, "R5 cas lead", cas_pre, CSR);
                check(!cu && !cl, "R5 both cas low", {cu, cl}, 0);
                check(we && gnt, "R7 we high and grant", {we, gnt}, 3);
            end
            if (!prev_ras && ras_n) begin
                check(low_len == RASL, "R6 ras width", low_len, RASL);
                have_rise = 1; gnt_held = 1; hi_run = 0;
            end
            if (!ras_n && (cu || cl)) check(0, "R5 cas cover", {cu, cl}, 0);
            if (prev_cu && !cu && have_rise && gnt_held)
                check(hi_run == PRE + 1, "R6 burst gap", hi_run, PRE + 1);
            if (prev_cu && !cu) have_rise = 0;
            if (!gnt) gnt_held = 0;
            cas_pre = (!cu && ras_n) ? cas_pre + 1 : 0;
            low_len = !ras_n ? low_len + 1 : 0;
            if (ras_n && cu && cl) hi_run++;
            prev_ras = ras_n;
            prev_cu  = cu;
        end
    end

    // grant responder with random latency
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (auto_gnt) begin
                if (req && !gnt) begin
                    if (dly == 0) gnt = 1'b1;
                    else dly--;
                end else if (!req && gnt) begin
                    gnt = 1'b0;
                    dly = $urandom_range(0, 20);
                end
            end
        end
    end

    // random activity pulses from the access path
    initial begin
        act = 1'b0;
        forever begin
            repeat ($urandom_range(20, 120)) @(negedge clk);
            if (act_en) begin
                act = 1'b1;
                @(negedge clk);
                act = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t, f0, la, seed;
        seed = $urandom(32'd7331);
        rst_n = 1'b0; gnt = 1'b0;
        repeat (5) @(negedge clk);
        check(!req && !ready, "R1 reset outputs", {req, ready}, 0);
        check(ras_n && cu && cl && we, "R7 reset strobes", {ras_n, cu, cl, we}, 15);

        // R1: power-up wait
        rst_n = 1'b1;
        t = 0;
        while (!req) begin
            @(negedge clk);
            t++;
            if (ready) check(0, "R1 ready during pause", 1, 0);
        end
        check(in_range(t, P - 1, P + 1), "R1 pause length", t, P);

        // R2: warm-up burst
        f0 = ras_falls;
        auto_gnt = 1; act_en = 1;
        while (!ready) @(negedge clk);
        check(ras_falls - f0 == WARM, "R2 warm-up count", ras_falls - f0, WARM);

        // R3/R4: steady refresh rate with random grant latency
        f0 = ras_falls;
        repeat (20 * TICK) @(negedge clk);
        check(in_range(ras_falls - f0, 19, 21), "R3 refresh rate", ras_falls - f0, 20);
        check(ready, "R9 ready held in service", ready, 1);

        // R3/R4/R9: withhold grant, credits saturate, drained under one grant
        while (!(req == 1'b0 && gnt == 1'b0)) @(negedge clk);
        auto_gnt = 0;
        while (!req) @(negedge clk);
        repeat (5 * TICK) @(negedge clk);
        check(ready, "R9 activity keeps ready", ready, 1);
        check(ras_n && cu && cl, "R7 no strobes without grant", {ras_n, cu, cl}, 7);
        f0 = ras_falls;
        gnt = 1'b1;
        @(negedge clk);
        while (req) @(negedge clk);
        check(ras_falls - f0 == MAXP, "R3 R4 backlog drain", ras_falls - f0, MAXP);
        gnt = 1'b0;

        // R8: idle expiry forces a new warm-up
        act_en = 0;
        repeat (3) @(negedge clk);
        la = last_act;
        while (cyc < la + IDLE - 10) @(negedge clk);
        check(ready, "R8 ready before limit", ready, 1);
        while (cyc < la + IDLE + 10) @(negedge clk);
        check(!ready, "R8 ready after limit", ready, 0);
        f0 = ras_falls;
        auto_gnt = 1;
        while (!ready) @(negedge clk);
        check(ras_falls - f0 == WARM, "R8 re-warm count", ras_falls - f0, WARM);

        // R4: service resumes
        act_en = 1;
        f0 = ras_falls;
        repeat (10 * TICK) @(negedge clk);
        check(in_range(ras_falls - f0, 9, 11), "R4 resumed refresh", ras_falls - f0, 10);
        check(ready, "R9 ready after resume", ready, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule